// File: doc/BRIEF.md
# USB Bus Reset and Resume Sequencer

This block times the bus-level events of a USB port from a 12 MHz sampling clock. It takes the receiver's decoded line state and handles three kinds of event. As a peripheral, it detects a bus reset held by the host and flags both its start and its end. Also as a peripheral, it performs remote-wakeup resume signaling once the bus has been idle long enough. As a host, it drives a timed bus reset on request. A separate watcher supports low-power operation: a falling edge on D+ requests an oscillator restart, and a stabilization count follows before a ready pulse.

Software or a register file drives the level inputs `host_mode`, `rwu_req`, `pwr_down` and `osc_wake_en`, and the one-cycle request `busrst_set`. The block returns one-cycle interrupt pulses. It also returns a registered line-drive request (`drive_en` with `drive_ls`) for the transceiver. Every interval is a parameter. The defaults are 256 clocks of SE0 for reset detection, 60000 clocks of idle before resume, 120000 clocks of K for resume, 600000 clocks of SE0 for a host reset and 2048 clocks of oscillator settling.

Top module: `usb_bus_seq`

## Requirements
- R1: In peripheral mode (`host_mode`=0), when `line_ls` is 2'b00 (SE0) for RST_DET_CYC consecutive clock samples, `irq_bus_rst` pulses high for exactly one cycle. It pulses only once however long SE0 lasts.
- R2: A run of SE0 shorter than RST_DET_CYC that ends in any other line state raises no `irq_bus_rst`, and the next SE0 run is counted from zero.
- R3: After a detected bus reset, the first sample whose line state is not SE0 produces exactly one `irq_bus_rst_end` pulse.
- R4: With `rwu_req` high in peripheral mode, K drive (`drive_en`=1, `drive_ls`=2'b10) begins only after `line_ls` has been 2'b01 (J, idle) for IDLE_CYC consecutive samples. Any sample that is not J restarts the idle count.
- R5: Resume K is driven for exactly RESUME_CYC cycles and then released, with one `irq_rwu_done` pulse. No further resume starts until `rwu_req` has returned low.
- R6: In host mode, a `busrst_set` pulse drives SE0 (`drive_en`=1, `drive_ls`=2'b00) for exactly HRST_CYC cycles. `busrst_busy` stays high during the reset and clears by itself at the end, and one `irq_bus_event` pulse marks completion.
- R7: In peripheral mode, `busrst_set` has no effect: no drive and `busrst_busy` stays 0. In host mode, SE0 on the line raises no `irq_bus_rst`.
- R8: When `pwr_down` and `osc_wake_en` are both high, a 1-to-0 change of `dp_in` gives one `osc_restart` pulse, and `osc_ready` pulses exactly OSC_CYC cycles later. Without `osc_wake_en`, a falling edge gives no restart.
- R9: While `rst` is high and directly after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 selects host operation, 0 selects peripheral |
| line_ls | input | 2 | Received line state: 00 SE0, 01 J, 10 K |
| dp_in | input | 1 | Raw D+ level for wake detection |
| rwu_req | input | 1 | Request remote-wakeup resume (level) |
| busrst_set | input | 1 | One-cycle request for a host bus reset |
| pwr_down | input | 1 | Port is in power-down |
| osc_wake_en | input | 1 | Allow D+ falling edge to restart the oscillator |
| drive_en | output | 1 | Transceiver drives the line |
| drive_ls | output | 2 | State to drive: 00 SE0, 10 K |
| busrst_busy | output | 1 | Host bus reset in progress (self-clearing) |
| irq_bus_rst | output | 1 | Pulse: bus reset detected |
| irq_bus_rst_end | output | 1 | Pulse: bus reset ended |
| irq_rwu_done | output | 1 | Pulse: resume signaling finished |
| irq_bus_event | output | 1 | Pulse: host bus reset finished |
| osc_restart | output | 1 | Pulse: restart the oscillator |
| osc_ready | output | 1 | Pulse: oscillator settling time elapsed |

## Verification
The assertions assume that `line_ls` changes only at clock edges and that `busrst_set` is a single-cycle request. They also assume that `dp_in` is already synchronized. The checks on the start of resume depend on IDLE_CYC being at least one. The bench changes every input just after a rising edge and holds each line state for whole cycles. It overrides every interval with a short value, so that each boundary can be reached exactly. The bench never switches `host_mode` while a sequence is running.

// File: rtl/usb_seq_pkg.sv
package usb_seq_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    RS_WAIT  = 2'b00,
    RS_DRIVE = 2'b01,
    RS_DONE  = 2'b10
  } rsm_t;
endpackage

// File: rtl/usb_rst_det.sv
module usb_rst_det
  import usb_seq_pkg::*;
#(
  parameter int DET_CYC = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] ls,
  output logic       rst_start,
  output logic       rst_end
);
  localparam int W = $clog2(DET_CYC + 1);

  logic [W-1:0] se0_cnt;
  logic         in_rst;
  logic         se0;

  assign se0 = (ls == LS_SE0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      se0_cnt   <= '0;
      in_rst    <= 1'b0;
      rst_start <= 1'b0;
      rst_end   <= 1'b0;
    end else begin
      rst_start <= 1'b0;
      rst_end   <= 1'b0;
      if (se0) begin
        if (!in_rst) begin
          if (se0_cnt == W'(DET_CYC - 1)) begin
            rst_start <= 1'b1;
            in_rst    <= 1'b1;
            se0_cnt   <= '0;
          end else begin
            se0_cnt <= se0_cnt + 1'b1;
          end
        end
      end else begin
        se0_cnt <= '0;
        if (in_rst) begin
          in_rst  <= 1'b0;
          rst_end <= 1'b1;
        end
      end
    end
  end

  AST_URES_ON_SE0: assert property (@(posedge clk) disable iff (rst)
    rst_start |-> ($past(ls) == LS_SE0)); // R1
  AST_URES_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rst_start |=> !rst_start); // R1
  AST_URESDN_OFF_SE0: assert property (@(posedge clk) disable iff (rst)
    rst_end |-> ($past(ls) != LS_SE0)); // R3
endmodule

// File: rtl/usb_resume.sv
module usb_resume
  import usb_seq_pkg::*;
#(
  parameter int IDLE_CYC = 60000,
  parameter int DRV_CYC  = 120000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] ls,
  input  logic       rwu_req,
  output logic       drive_k,
  output logic       done_irq
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int DW = $clog2(DRV_CYC + 1);

  rsm_t          st;
  logic [IW-1:0] idle_cnt;
  logic [DW-1:0] drv_cnt;
  logic          idle_ok;

  assign idle_ok = (idle_cnt == IW'(IDLE_CYC));
  assign drive_k = (st == RS_DRIVE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st       <= RS_WAIT;
      idle_cnt <= '0;
      drv_cnt  <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (ls == LS_J) begin
        if (!idle_ok) idle_cnt <= idle_cnt + 1'b1;
      end else begin
        idle_cnt <= '0;
      end
      case (st)
        RS_WAIT: begin
          if (rwu_req && idle_ok) begin
            st      <= RS_DRIVE;
            drv_cnt <= '0;
          end
        end
        RS_DRIVE: begin
          if (drv_cnt == DW'(DRV_CYC - 1)) begin
            st       <= RS_DONE;
            done_irq <= 1'b1;
          end else begin
            drv_cnt <= drv_cnt + 1'b1;
          end
        end
        RS_DONE: begin
          if (!rwu_req) st <= RS_WAIT;
        end
        default: st <= RS_WAIT;
      endcase
    end
  end

  AST_RESUME_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_k) |-> ($past(ls, 2) == LS_J)); // R4
  AST_RWUDN_AT_END: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> ($past(drive_k) && !drive_k)); // R5
endmodule

// File: rtl/usb_host_rst.sv
module usb_host_rst #(
  parameter int RST_CYC = 600000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  output logic busy,
  output logic done_irq
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy     <= 1'b0;
      cnt      <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (cnt == CW'(RST_CYC - 1)) begin
        busy     <= 1'b0;
        done_irq <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_BUSEVT_END: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (!busy && $past(busy))); // R6
  AST_NO_HRST_PERIPH: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy); // R7
endmodule

// File: rtl/usb_osc_wake.sv
module usb_osc_wake #(
  parameter int STAB_CYC = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic dp,
  output logic restart,
  output logic ready
);
  localparam int CW = $clog2(STAB_CYC + 1);

  logic [CW-1:0] cnt;
  logic          dp_q;
  logic          waiting;
  logic          fall;

  assign fall = dp_q && !dp;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_q    <= 1'b0;
      waiting <= 1'b0;
      cnt     <= '0;
      restart <= 1'b0;
      ready   <= 1'b0;
    end else begin
      dp_q    <= dp;
      restart <= 1'b0;
      ready   <= 1'b0;
      if (!waiting) begin
        if (arm && fall) begin
          restart <= 1'b1;
          waiting <= 1'b1;
          cnt     <= '0;
        end
      end else if (cnt == CW'(STAB_CYC - 1)) begin
        waiting <= 1'b0;
        ready   <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_OSC_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({restart, ready})); // R8
  AST_RESTART_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    restart |-> (!$past(dp) && $past(arm))); // R8
endmodule

// File: rtl/usb_bus_seq.sv
module usb_bus_seq
  import usb_seq_pkg::*;
#(
  parameter int RST_DET_CYC = 256,
  parameter int IDLE_CYC    = 60000,
  parameter int RESUME_CYC  = 120000,
  parameter int HRST_CYC    = 600000,
  parameter int OSC_CYC     = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_mode,
  input  logic [1:0] line_ls,
  input  logic       dp_in,
  input  logic       rwu_req,
  input  logic       busrst_set,
  input  logic       pwr_down,
  input  logic       osc_wake_en,
  output logic       drive_en,
  output logic [1:0] drive_ls,
  output logic       busrst_busy,
  output logic       irq_bus_rst,
  output logic       irq_bus_rst_end,
  output logic       irq_rwu_done,
  output logic       irq_bus_event,
  output logic       osc_restart,
  output logic       osc_ready
);
  logic periph_en;
  logic res_drive;
  logic h_busy;

  assign periph_en = !host_mode;

  usb_rst_det #(.DET_CYC(RST_DET_CYC)) u_det (
    .clk(clk), .rst(rst), .en(periph_en), .ls(line_ls),
    .rst_start(irq_bus_rst), .rst_end(irq_bus_rst_end)
  );

  usb_resume #(.IDLE_CYC(IDLE_CYC), .DRV_CYC(RESUME_CYC)) u_res (
    .clk(clk), .rst(rst), .en(periph_en), .ls(line_ls), .rwu_req(rwu_req),
    .drive_k(res_drive), .done_irq(irq_rwu_done)
  );

  usb_host_rst #(.RST_CYC(HRST_CYC)) u_hrst (
    .clk(clk), .rst(rst), .en(host_mode), .start(busrst_set),
    .busy(h_busy), .done_irq(irq_bus_event)
  );

  usb_osc_wake #(.STAB_CYC(OSC_CYC)) u_osc (
    .clk(clk), .rst(rst), .arm(pwr_down && osc_wake_en), .dp(dp_in),
    .restart(osc_restart), .ready(osc_ready)
  );

  assign busrst_busy = h_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en <= 1'b0;
      drive_ls <= LS_SE0;
    end else begin
      drive_en <= h_busy || res_drive;
      drive_ls <= h_busy ? LS_SE0 : (res_drive ? LS_K : LS_SE0);
    end
  end

  AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(h_busy && res_drive)); // R7
  AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> ($past(h_busy) || $past(res_drive))); // R6
endmodule

// File: tb/usb_bus_seq_tb.sv
module usb_bus_seq_tb;
  localparam int P_DET  = 8;
  localparam int P_IDLE = 20;
  localparam int P_RES  = 30;
  localparam int P_HRST = 40;
  localparam int P_OSC  = 16;
  localparam int NVEC   = 5;
  // SE0 run length, expected bus-reset pulses
  localparam int VEC [NVEC][2] = '{'{7, 0}, '{8, 1}, '{12, 1}, '{3, 0}, '{1, 0}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_mode = 1'b0;
  logic [1:0] line_ls = 2'b01;
  logic dp_in = 1'b1;
  logic rwu_req = 1'b0;
  logic busrst_set = 1'b0;
  logic pwr_down = 1'b0;
  logic osc_wake_en = 1'b0;
  logic drive_en, busrst_busy, irq_bus_rst, irq_bus_rst_end;
  logic irq_rwu_done, irq_bus_event, osc_restart, osc_ready;
  logic [1:0] drive_ls;

  int nchk = 0, nbad = 0, cyc = 0;
  int n_ures = 0, n_uresdn = 0, n_rwudn = 0, n_busevt = 0;
  int n_restart = 0, n_ready = 0, n_k = 0, n_se0 = 0;
  int t_restart = 0, t_ready = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usb_bus_seq #(.RST_DET_CYC(P_DET), .IDLE_CYC(P_IDLE), .RESUME_CYC(P_RES),
                .HRST_CYC(P_HRST), .OSC_CYC(P_OSC)) u_dut (
    .clk(clk), .rst(rst), .host_mode(host_mode), .line_ls(line_ls),
    .dp_in(dp_in), .rwu_req(rwu_req), .busrst_set(busrst_set),
    .pwr_down(pwr_down), .osc_wake_en(osc_wake_en), .drive_en(drive_en),
    .drive_ls(drive_ls), .busrst_busy(busrst_busy), .irq_bus_rst(irq_bus_rst),
    .irq_bus_rst_end(irq_bus_rst_end), .irq_rwu_done(irq_rwu_done),
    .irq_bus_event(irq_bus_event), .osc_restart(osc_restart), .osc_ready(osc_ready)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (irq_bus_rst)     n_ures++;
      if (irq_bus_rst_end) n_uresdn++;
      if (irq_rwu_done)    n_rwudn++;
      if (irq_bus_event)   n_busevt++;
      if (osc_restart) begin n_restart++; t_restart = cyc; end
      if (osc_ready)   begin n_ready++;   t_ready = cyc;   end
      if (drive_en && drive_ls == 2'b10) n_k++;
      if (drive_en && drive_ls == 2'b00) n_se0++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic hold_ls(input logic [1:0] v, input int n);
    line_ls = v;
    step(n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int b0, b1, b2, b3;
    step(4);
    @(negedge clk);
    chk("R9 outputs in reset", {drive_en, drive_ls, busrst_busy, irq_bus_rst,
        irq_bus_rst_end, irq_rwu_done, irq_bus_event, osc_restart, osc_ready}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    step(2);
    @(negedge clk);
    chk("R9 outputs after reset", {drive_en, drive_ls, busrst_busy, irq_bus_rst,
        irq_bus_rst_end, irq_rwu_done, irq_bus_event, osc_restart, osc_ready}, 0);
    @(posedge clk); #1;

    // R1 R2 R3: table of SE0 run lengths
    for (int i = 0; i < NVEC; i++) begin
      b0 = n_ures; b1 = n_uresdn;
      hold_ls(2'b01, 3);
      hold_ls(2'b00, VEC[i][0]);
      hold_ls(2'b01, 3);
      chk(VEC[i][1] != 0 ? "R1 reset pulse count" : "R2 short SE0 ignored",
          n_ures - b0, VEC[i][1]);
      chk("R3 reset-end pulse count", n_uresdn - b1, VEC[i][1]);
    end

    // R2: two short runs separated by J do not add up
    b0 = n_ures;
    hold_ls(2'b00, 5); hold_ls(2'b01, 1); hold_ls(2'b00, 5); hold_ls(2'b01, 3);
    chk("R2 counter restarts", n_ures - b0, 0);

    // R4 R5: resume gated by idle
    hold_ls(2'b10, 1);
    rwu_req = 1'b1;
    b0 = n_k; b1 = n_rwudn;
    hold_ls(2'b01, 15);
    hold_ls(2'b10, 1);
    hold_ls(2'b01, 15);
    chk("R4 no resume before idle", n_k - b0, 0);
    hold_ls(2'b01, 60);
    chk("R5 resume length", n_k - b0, P_RES);
    chk("R5 resume done pulse", n_rwudn - b1, 1);
    hold_ls(2'b01, 50);
    chk("R5 no second resume", n_k - b0, P_RES);
    @(negedge clk);
    chk("R5 line released", drive_en, 0);
    @(posedge clk); #1;
    rwu_req = 1'b0;
    step(2);

    // R6: host bus reset
    host_mode = 1'b1;
    step(2);
    b0 = n_se0; b1 = n_busevt;
    busrst_set = 1'b1; step(1); busrst_set = 1'b0;
    step(5);
    chk("R6 busy during reset", busrst_busy, 1);
    step(60);
    chk("R6 busy self-clears", busrst_busy, 0);
    chk("R6 SE0 drive length", n_se0 - b0, P_HRST);
    chk("R6 bus event pulse", n_busevt - b1, 1);

    // R7: no detection in host mode
    b0 = n_ures;
    hold_ls(2'b00, 20);
    hold_ls(2'b01, 3);
    chk("R7 no reset detect in host mode", n_ures - b0, 0);
    host_mode = 1'b0;
    step(2);
    b0 = n_se0;
    busrst_set = 1'b1; step(1); busrst_set = 1'b0;
    step(3);
    chk("R7 busy stays low in peripheral", busrst_busy, 0);
    step(50);
    chk("R7 no SE0 drive in peripheral", n_se0 - b0, 0);

    // R8: oscillator wake
    pwr_down = 1'b1;
    b0 = n_restart; b1 = n_ready;
    dp_in = 1'b1; step(3);
    dp_in = 1'b0; step(5);
    chk("R8 no restart when disabled", n_restart - b0, 0);
    dp_in = 1'b1; step(3);
    osc_wake_en = 1'b1; step(1);
    dp_in = 1'b0; step(30);
    b2 = n_restart - b0; b3 = n_ready - b1;
    chk("R8 restart pulse", b2, 1);
    chk("R8 ready pulse", b3, 1);
    chk("R8 settling delay", t_ready - t_restart, P_OSC);

    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule